// File: doc/BRIEF.md
# Floating-Point Normalize and Round Unit

This block finishes an arithmetic result. It takes an unnormalized value: a signed exponent, a sign, a fraction and an optional low-order extension word. It returns the final value with a guard flag and a range status. Normalization moves the fraction and the extension together as one double-length register, one bit to the left per clock, until the fraction's leading bit is set. Each shift lowers the exponent by one. Rounding then looks at the leading bit of what is left in the extension. The range check compares the finished exponent with the limits of an 18-bit two's-complement field.

The block uses a valid/ready handshake on both sides. An operand is taken on a cycle in which `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle. A result stays on the outputs, with `out_valid` high and every field unchanged, until the consumer raises `out_ready`. The unit then returns to idle on the following clock and accepts no new operand before then. Two modifier inputs can skip the shift loop or the increment. A round-request input asks for rounding, which also needs the extension to be marked present.

Top module: `nr_normround`

## Requirements
- R1: Only bits 34..0 of `in_frac` and `in_ext` are used; bit 35 of either is ignored. When `in_has_ext` is 0, the extension is taken as all zeros whatever `in_ext` holds.
- R2: With normalization enabled and fraction:extension nonzero, the 70-bit pair moves left one place per clock until fraction bit 34 is 1. The exponent drops by one per shift. `out_valid` first rises k+2 rising edges after the accepting edge, where k is the number of shifts.
- R3: With normalization enabled and both fraction and extension zero, the result is a true zero: sign 0, exponent 0, fraction 0.
- R4: When `in_round`=1, `in_has_ext`=1 and the extension's bit 34 is 1 after normalization, `out_guard` is 1 and the fraction is incremented by one. In every other case `out_guard` is 0.
- R5: If that increment carries out of bit 34, the fraction becomes exactly bit 34 set and the exponent rises by one.
- R6: With `in_no_round`=1, the guard bit is still set as in R4, but the fraction and exponent are left unchanged.
- R7: With `in_no_norm`=1, the shift loop and the true-zero step are skipped, so k=0 and a zero keeps its sign and exponent. Rounding and the range check still apply.
- R8: `out_status` is 1 (overflow) when the final exponent exceeds +131071, 2 (underflow) when it is below -131072, and 0 otherwise.
- R9: `in_ready` is low from acceptance until the result is taken. While `out_valid`=1 and `out_ready`=0, all result outputs hold. In the cycle after the result is taken, `out_valid` is 0 and `in_ready` is 1.
- R10: After reset, `in_ready`=1 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand will be taken |
| in_exp | input | EXP_W+2 (20) | Signed input exponent |
| in_sign | input | 1 | Input sign, 1 = negative |
| in_frac | input | FRAC_W+1 (36) | Fraction; top bit is ignored |
| in_ext | input | FRAC_W+1 (36) | Low extension; top bit is ignored |
| in_has_ext | input | 1 | Extension word present |
| in_round | input | 1 | Rounding requested |
| in_no_norm | input | 1 | Skip normalization |
| in_no_round | input | 1 | Suppress the rounding increment |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_exp | output | EXP_W+3+clog2(2*FRAC_W) (28) | Signed final exponent |
| out_sign | output | 1 | Final sign |
| out_frac | output | FRAC_W (35) | Final fraction |
| out_guard | output | 1 | Extension leading bit consumed by rounding |
| out_status | output | 2 | 0 OK, 1 overflow, 2 underflow |

## Verification
The bench builds the unit with its default widths: a 35-bit fraction and an 18-bit exponent range. At these widths the longest normalization, 69 shifts from a lone extension bit at position 0, fits easily in the run. Both range limits, +131071 and -131072, can be reached directly from the 20-bit input exponent. The bench places results on each side of each limit. Some get there through a rounding carry and some through normalization decrements.

// File: rtl/nr_pkg.sv
package nr_pkg;
  typedef enum logic [1:0] {
    NR_IDLE  = 2'd0,
    NR_SHIFT = 2'd1,
    NR_ROUND = 2'd2,
    NR_DONE  = 2'd3
  } nr_state_e;

  typedef enum logic [1:0] {
    NR_OK  = 2'd0,
    NR_OVF = 2'd1,
    NR_UNF = 2'd2
  } nr_status_e;
endpackage

// File: rtl/nr_ctrl.sv
module nr_ctrl
  import nr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic no_norm_i,
  input  logic nonzero_i,
  input  logic lead_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic load_o,
  output logic shift_o,
  output logic zero_o,
  output logic round_o
);
  nr_state_e state_q, state_d;

  always_comb begin
    in_ready_o  = (state_q == NR_IDLE);
    out_valid_o = (state_q == NR_DONE);
    load_o      = (state_q == NR_IDLE) && in_valid;
    shift_o     = (state_q == NR_SHIFT) && !no_norm_i && nonzero_i && !lead_i;
    zero_o      = (state_q == NR_SHIFT) && !no_norm_i && !nonzero_i;
    round_o     = (state_q == NR_ROUND);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      NR_IDLE:  if (in_valid) state_d = NR_SHIFT;
      NR_SHIFT: if (!shift_o) state_d = NR_ROUND;
      NR_ROUND: state_d = NR_DONE;
      NR_DONE:  if (out_ready) state_d = NR_IDLE;
      default:  state_d = NR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= NR_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/nr_round.sv
module nr_round #(
  parameter int FRAC_W = 35,
  parameter int XW     = 28
) (
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic signed [XW-1:0] exp_i,
  input  logic                 hit_i,
  input  logic                 no_round_i,
  output logic [FRAC_W-1:0]    frac_o,
  output logic signed [XW-1:0] exp_o,
  output logic                 guard_o
);
  localparam logic [FRAC_W-1:0] LEAD_ONLY = {1'b1, {(FRAC_W-1){1'b0}}};
  logic [FRAC_W:0] inc;

  always_comb begin
    inc     = {1'b0, frac_i} + (FRAC_W+1)'(1);
    frac_o  = frac_i;
    exp_o   = exp_i;
    guard_o = hit_i;
    if (hit_i && !no_round_i) begin
      if (inc[FRAC_W]) begin
        frac_o = LEAD_ONLY;
        exp_o  = exp_i + XW'(1);
      end else begin
        frac_o = inc[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/nr_range.sv
module nr_range
  import nr_pkg::*;
#(
  parameter int EXP_W = 18,
  parameter int XW    = 28
) (
  input  logic signed [XW-1:0] exp_i,
  output logic [1:0]           status_o
);
  localparam logic signed [XW-1:0] HI = XW'((64'sd1 <<< (EXP_W-1)) - 64'sd1);
  localparam logic signed [XW-1:0] LO = XW'(-(64'sd1 <<< (EXP_W-1)));

  always_comb begin
    if (exp_i > HI)      status_o = NR_OVF;
    else if (exp_i < LO) status_o = NR_UNF;
    else                 status_o = NR_OK;
  end
endmodule

// File: rtl/nr_normround.sv
module nr_normround
  import nr_pkg::*;
#(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 18,
  localparam int EXP_IN_W = EXP_W + 2,
  localparam int XW       = EXP_IN_W + $clog2(2*FRAC_W) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [EXP_IN_W-1:0] in_exp,
  input  logic                in_sign,
  input  logic [FRAC_W:0]     in_frac,
  input  logic [FRAC_W:0]     in_ext,
  input  logic                in_has_ext,
  input  logic                in_round,
  input  logic                in_no_norm,
  input  logic                in_no_round,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [XW-1:0]       out_exp,
  output logic                out_sign,
  output logic [FRAC_W-1:0]   out_frac,
  output logic                out_guard,
  output logic [1:0]          out_status
);
  logic [FRAC_W-1:0]    frac_q, ext_q, frac_r;
  logic signed [XW-1:0] exp_q, exp_r;
  logic                 sign_q, guard_q, guard_r;
  logic                 has_ext_q, round_q, no_norm_q, no_round_q;
  logic [1:0]           status_q, status_r;
  logic                 load, shift, zero, rstep;

  nr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .no_norm_i  (no_norm_q),
    .nonzero_i  (|{frac_q, ext_q}),
    .lead_i     (frac_q[FRAC_W-1]),
    .in_ready_o (in_ready),
    .out_valid_o(out_valid),
    .load_o     (load),
    .shift_o    (shift),
    .zero_o     (zero),
    .round_o    (rstep)
  );

  nr_round #(.FRAC_W(FRAC_W), .XW(XW)) u_round (
    .frac_i    (frac_q),
    .exp_i     (exp_q),
    .hit_i     (round_q && has_ext_q && ext_q[FRAC_W-1]),
    .no_round_i(no_round_q),
    .frac_o    (frac_r),
    .exp_o     (exp_r),
    .guard_o   (guard_r)
  );

  nr_range #(.EXP_W(EXP_W), .XW(XW)) u_range (
    .exp_i   (exp_r),
    .status_o(status_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q     <= '0;
      ext_q      <= '0;
      exp_q      <= '0;
      sign_q     <= 1'b0;
      guard_q    <= 1'b0;
      status_q   <= NR_OK;
      has_ext_q  <= 1'b0;
      round_q    <= 1'b0;
      no_norm_q  <= 1'b0;
      no_round_q <= 1'b0;
    end else if (load) begin
      frac_q     <= in_frac[FRAC_W-1:0];
      ext_q      <= in_has_ext ? in_ext[FRAC_W-1:0] : '0;
      exp_q      <= {{(XW-EXP_IN_W){in_exp[EXP_IN_W-1]}}, in_exp};
      sign_q     <= in_sign;
      guard_q    <= 1'b0;
      status_q   <= NR_OK;
      has_ext_q  <= in_has_ext;
      round_q    <= in_round;
      no_norm_q  <= in_no_norm;
      no_round_q <= in_no_round;
    end else if (shift) begin
      {frac_q, ext_q} <= {frac_q[FRAC_W-2:0], ext_q, 1'b0};
      exp_q           <= exp_q - XW'(1);
    end else if (zero) begin
      sign_q <= 1'b0;
      exp_q  <= '0;
    end else if (rstep) begin
      frac_q   <= frac_r;
      exp_q    <= exp_r;
      guard_q  <= guard_r;
      status_q <= status_r;
    end
  end

  assign out_exp    = exp_q;
  assign out_sign   = sign_q;
  assign out_frac   = frac_q;
  assign out_guard  = guard_q;
  assign out_status = status_q;
endmodule

// File: rtl/nr_normround_chk.sv
module nr_normround_chk #(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 18,
  parameter int XW     = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XW-1:0]     out_exp,
  input logic              out_sign,
  input logic [FRAC_W-1:0] out_frac,
  input logic              out_guard,
  input logic [1:0]        out_status,
  input logic              no_norm_q,
  input logic              round_q,
  input logic              has_ext_q
);
  localparam logic signed [XW-1:0] HI = XW'((64'sd1 <<< (EXP_W-1)) - 64'sd1);
  localparam logic signed [XW-1:0] LO = XW'(-(64'sd1 <<< (EXP_W-1)));

  AST_READY_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_frac) && $stable(out_exp)
      && $stable(out_sign) && $stable(out_guard) && $stable(out_status)); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready); // R9
  AST_NORM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !no_norm_q && (out_frac != '0) |-> out_frac[FRAC_W-1]); // R2
  AST_TRUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !no_norm_q && (out_frac == '0) |-> !out_sign && (out_exp == '0)); // R3
  AST_GUARD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_guard |-> round_q && has_ext_q); // R4
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_status == 2'd1) == ($signed(out_exp) > HI))); // R8
  AST_UNF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_status == 2'd2) == ($signed(out_exp) < LO))); // R8
endmodule

bind nr_normround nr_normround_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .XW(XW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_exp   (out_exp),
  .out_sign  (out_sign),
  .out_frac  (out_frac),
  .out_guard (out_guard),
  .out_status(out_status),
  .no_norm_q (no_norm_q),
  .round_q   (round_q),
  .has_ext_q (has_ext_q)
);

// File: tb/nr_normround_test.sv
`timescale 1ns/1ps
module nr_normround_test;
  localparam int FW = 35;
  localparam int XW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [19:0]   in_exp = '0;
  logic          in_sign = 1'b0;
  logic [FW:0]   in_frac = '0;
  logic [FW:0]   in_ext = '0;
  logic          in_has_ext = 1'b0;
  logic          in_round = 1'b0;
  logic          in_no_norm = 1'b0;
  logic          in_no_round = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [XW-1:0] out_exp;
  logic          out_sign;
  logic [FW-1:0] out_frac;
  logic          out_guard;
  logic [1:0]    out_status;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nr_normround uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_exp(in_exp), .in_sign(in_sign), .in_frac(in_frac), .in_ext(in_ext),
    .in_has_ext(in_has_ext), .in_round(in_round), .in_no_norm(in_no_norm),
    .in_no_round(in_no_round), .out_valid(out_valid), .out_ready(out_ready),
    .out_exp(out_exp), .out_sign(out_sign), .out_frac(out_frac),
    .out_guard(out_guard), .out_status(out_status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One operand through the unit; the reference result is computed here.
  task automatic run(input string tag, input longint exp_in, input bit sgn,
                     input logic [FW:0] fr, input logic [FW:0] ex,
                     input bit hx, input bit rq, input bit nn, input bit nr,
                     input int hold);
    logic [FW-1:0] f;
    logic [FW-1:0] x;
    longint e;
    bit s, g;
    int k, st, n;
    logic [FW-1:0] sf;
    logic [XW-1:0] se;
    f = fr[FW-1:0];
    x = hx ? ex[FW-1:0] : '0;
    e = exp_in; s = sgn; g = 0; k = 0;
    if (!nn) begin
      if ((f | x) != '0) begin
        while (!f[FW-1]) begin
          {f, x} = {f, x} << 1;
          e = e - 1;
          k++;
        end
      end else begin
        s = 0; e = 0;
      end
    end
    if (rq && hx && x[FW-1]) begin
      g = 1;
      if (!nr) begin
        if (f == '1) begin
          f = {1'b1, {(FW-1){1'b0}}};
          e = e + 1;
        end else f = f + 1'b1;
      end
    end
    st = (e > 131071) ? 1 : (e < -131072) ? 2 : 0;

    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready idle", in_ready, 1);
    in_exp = exp_in[19:0]; in_sign = sgn; in_frac = fr; in_ext = ex;
    in_has_ext = hx; in_round = rq; in_no_norm = nn; in_no_round = nr;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 300) begin
      chk(in_ready == 1'b0, "R9", "in_ready busy", in_ready, 0);
      @(negedge clk);
      n++;
    end
    chk(n == k + 2, "R2", "latency", n, k + 2);
    chk(out_frac == f, tag, "frac", out_frac, f);
    chk($signed(out_exp) == e, tag, "exp", $signed(out_exp), e);
    chk(out_sign == s, tag, "sign", out_sign, s);
    chk(out_guard == g, tag, "guard", out_guard, g);
    chk(out_status == st[1:0], tag, "status", out_status, st);
    sf = out_frac; se = out_exp;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(out_valid && out_frac == sf && out_exp == se, "R9", "hold", out_frac, sf);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R9", "release", {out_valid, in_ready}, 1);
  endtask

  localparam logic [FW:0] LEAD = 36'h1 << 34;
  localparam logic [FW:0] ONES = {1'b0, {FW{1'b1}}};

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R10", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    // tag, exp, sign, frac, ext, has_ext, round, no_norm, no_round, hold
    run("R2", 5, 0, LEAD, 0, 0, 0, 0, 0, 0);
    run("R2", 10, 1, 36'h1, 0, 0, 0, 0, 0, 2);
    run("R2", 0, 0, 0, LEAD, 1, 0, 0, 0, 0);
    run("R2", 100, 0, 0, 36'h1, 1, 0, 0, 0, 0);
    run("R2", -7, 1, 36'h3, LEAD | 36'h5, 1, 0, 0, 0, 0);
    run("R3", 77, 1, 0, 0, 1, 1, 0, 0, 0);
    run("R1", 12, 0, 36'h8_0000_0000 | LEAD, 36'h8_0000_0000, 1, 1, 0, 0, 0);
    run("R1", 4, 0, 36'h8_0000_0000, 36'h1, 0, 0, 0, 0, 0);
    run("R1", 3, 0, LEAD | 36'h1, LEAD, 0, 1, 0, 0, 0);
    run("R4", 3, 0, LEAD | 36'h1, LEAD, 1, 1, 0, 0, 0);
    run("R4", 3, 1, LEAD | 36'h1, LEAD, 1, 0, 0, 0, 0);
    run("R5", 3, 0, ONES, LEAD, 1, 1, 0, 0, 3);
    run("R6", 3, 0, ONES, LEAD, 1, 1, 0, 1, 0);
    run("R7", 9, 0, 36'h1, 0, 0, 0, 1, 0, 0);
    run("R7", 9, 1, 0, 0, 0, 0, 1, 0, 0);
    run("R7", 131071, 0, ONES, LEAD, 1, 1, 1, 0, 0);
    run("R8", 131071, 0, ONES, LEAD, 1, 1, 0, 0, 0);
    run("R8", 131071, 0, LEAD, 0, 0, 0, 0, 0, 0);
    run("R8", 131072, 0, LEAD, 0, 0, 0, 0, 0, 0);
    run("R8", -131072, 1, LEAD, 0, 0, 0, 0, 0, 0);
    run("R8", -131072, 0, 36'h2_0000_0000, 0, 0, 0, 0, 0, 0);
    run("R8", -131071, 0, 36'h2_0000_0000, 0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule